// File: doc/BRIEF.md
# Receive Frame Validation Unit

This unit sits between a baseband byte interface and a shared frame memory. It takes in the bytes of one incoming wireless MAC frame and runs a 32-bit CRC over every byte as it arrives. It counts the frame length and captures the protocol version from the first byte. While it waits for the shared memory bus, it holds the bytes in a small staging buffer. Once the bus is granted, it drains the buffer into memory at one byte per cycle. It signals a chunk reservation to the allocation map each time a write opens a new chunk.

When the frame is complete and fully written, the unit emits a one-cycle token for the downstream filter stage. The token comes with a status word, the frame length and the number of chunks reserved. A clean frame is passed on as an accept. Any error turns the token into a release, so that the reserved chunks are freed. If the staging buffer fills before the bus is granted, the frame is dropped and only the overrun flag is reported. The CRC seed and the good-frame residue are loaded at initialisation, so software decides both.

Top module: `rx_frame_validator`

## Requirements
- R1: While reset is asserted and right after it, busReq, memWrite, allocStrobe, tokenValid, tokenAccept and tokenRelease are all low.
- R2: The CRC uses the bit-reflected form of polynomial 0x04C11DB7 (0xEDB88320), shifting right with data taken LSB first. It starts from the seed and covers every byte including the 4-byte FCS. If the final register differs from the residue, tokenStatus bit 0 is set.
- R3: A cycle with initLoad high loads initSeed and initResidue for later frames. Out of reset the seed is 0xFFFFFFFF and the residue is 0xDEBB20E3 (0xC704DD7B in the conventional bit order).
- R4: frameLen reports the byte count, FCS included. tokenStatus bit 1 is set when that count is below 14 or above maxLen.
- R5: tokenStatus bit 2 is set when bits [1:0] of the first frame byte are not zero.
- R6: busReq is high from the cycle after the first byte up to, but not including, the token cycle. memWrite occurs only while busGrant and busReq are both high, and memData carries the frame bytes in arrival order, one per write.
- R7: If a byte arrives while the 8-byte staging buffer is full and no write takes place that cycle, the frame is dropped. tokenStatus is then exactly 4'b1000 (bit 3 = overrun), busReq drops, no further writes occur, and the token comes in the cycle after the frame's last byte.
- R8: allocStrobe pulses together with every write whose byte index within the frame is a multiple of 16. tokenChunks reports how many such pulses the frame produced.
- R9: The token is a single-cycle pulse, one cycle after the frame's final memory write. tokenAccept is high exactly when tokenStatus is zero, tokenRelease is high otherwise, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initLoad | input | 1 | Load seed and residue |
| initSeed | input | 32 | CRC start value to load |
| initResidue | input | 32 | Good-frame CRC residue to load |
| maxLen | input | 16 | Largest allowed frame length in bytes |
| rxValid | input | 1 | Byte present on rxData |
| rxData | input | 8 | Incoming frame byte |
| rxLast | input | 1 | Marks the final byte of the frame |
| busReq | output | 1 | Request for the shared memory bus |
| busGrant | input | 1 | Bus granted to this unit |
| memWrite | output | 1 | Frame byte written this cycle |
| memData | output | 8 | Byte being written |
| allocStrobe | output | 1 | Reserve a new memory chunk |
| tokenValid | output | 1 | Result token for the filter stage |
| tokenAccept | output | 1 | Token passes the frame on |
| tokenRelease | output | 1 | Token frees the reserved chunks |
| tokenStatus | output | 4 | Error flags: 0 CRC, 1 length, 2 version, 3 overrun |
| tokenChunks | output | 12 | Chunks reserved for the frame |
| frameLen | output | 16 | Received byte count |

## Verification
Each byte becomes writable in the cycle after it arrives, and busReq rises one cycle after the first byte. The token follows the final write by exactly one cycle, or follows the last byte by one cycle when the frame was dropped. A monitor samples at the falling edge and records the cycle index of the last byte, of every write and of the token. The bench then compares those indices with these fixed offsets, instead of waiting loosely for a result. Overrun is predicted from the grant delay: a grant that arrives later than the eighth byte's cycle means the ninth byte overflows.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  // Status flag positions in tokenStatus
  localparam int STAT_CRC  = 0;
  localparam int STAT_LEN  = 1;
  localparam int STAT_VER  = 2;
  localparam int STAT_OVR  = 3;
  localparam int STAT_W    = 4;

  typedef struct packed {
    logic start;    // first byte of a new frame
    logic push;     // byte enters the staging buffer
    logic pop;      // head byte goes to memory
    logic flush;    // discard staging contents
    logic dropped;  // current frame was overrun
  } rxvStrobe_t;
endpackage

// File: rtl/rxv_datapath.sv
module rxv_datapath
  import rxv_pkg::*;
#(
  parameter int          DEPTH         = 8,
  parameter int          CHUNK_BYTES   = 16,
  parameter int          LEN_W         = 16,
  parameter int          CHUNK_CNT_W   = 12,
  parameter int          MIN_LEN       = 14,
  parameter logic [31:0] CRC_POLY_REFL = 32'hEDB88320,
  parameter logic [31:0] RESET_SEED    = 32'hFFFFFFFF,
  parameter logic [31:0] RESET_RESIDUE = 32'hDEBB20E3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   initLoad,
  input  logic [31:0]            initSeed,
  input  logic [31:0]            initResidue,
  input  logic [LEN_W-1:0]       maxLen,
  input  logic [7:0]             rxData,
  input  rxvStrobe_t             strb,
  output logic                   fifoEmpty,
  output logic                   fifoOne,
  output logic                   fifoFull,
  output logic [7:0]             memData,
  output logic                   allocStrobe,
  output logic [STAT_W-1:0]      tokenStatus,
  output logic [CHUNK_CNT_W-1:0] tokenChunks,
  output logic [LEN_W-1:0]       frameLen
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OFS_W = $clog2(CHUNK_BYTES);

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      r = {1'b0, r[31:1]} ^ ({32{r[0] ^ d[b]}} & CRC_POLY_REFL);
    end
    return r;
  endfunction

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [7:0]             stage [DEPTH];
  logic [PTR_W-1:0]       wrPtr, rdPtr;
  logic [CNT_W-1:0]       count;
  logic [31:0]            crcSeed, crcResidue, crcReg;
  logic [LEN_W-1:0]       lenCnt;
  logic [1:0]             verField;
  logic [OFS_W-1:0]       wrIdx;
  logic [CHUNK_CNT_W-1:0] chunkCnt;

  // Staging buffer storage
  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) stage[wrPtr] <= rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= ptrInc(wrPtr);
      if (strb.pop)  rdPtr <= ptrInc(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign fifoEmpty = (count == '0);
  assign fifoOne   = (count == CNT_W'(1));
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign memData   = stage[rdPtr];

  // CRC, length and version capture on the arrival side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcSeed    <= RESET_SEED;
      crcResidue <= RESET_RESIDUE;
      crcReg     <= '0;
      lenCnt     <= '0;
      verField   <= '0;
    end else begin
      if (initLoad) begin
        crcSeed    <= initSeed;
        crcResidue <= initResidue;
      end
      if (strb.push) begin
        crcReg <= crcStep(strb.start ? crcSeed : crcReg, rxData);
        if (strb.start)                lenCnt <= LEN_W'(1);
        else if (lenCnt != '1)         lenCnt <= lenCnt + LEN_W'(1);
      end
      if (strb.start) verField <= rxData[1:0];
    end
  end

  // Chunk reservation on the memory side
  assign allocStrobe = strb.pop && (wrIdx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx    <= '0;
      chunkCnt <= '0;
    end else if (strb.start) begin
      wrIdx    <= '0;
      chunkCnt <= '0;
    end else if (strb.pop) begin
      wrIdx <= wrIdx + OFS_W'(1);
      if (allocStrobe) chunkCnt <= chunkCnt + CHUNK_CNT_W'(1);
    end
  end

  always_comb begin
    tokenStatus = '0;
    if (strb.dropped) begin
      tokenStatus[STAT_OVR] = 1'b1;
    end else begin
      tokenStatus[STAT_CRC] = (crcReg != crcResidue);
      tokenStatus[STAT_LEN] = (lenCnt < LEN_W'(MIN_LEN)) || (lenCnt > maxLen);
      tokenStatus[STAT_VER] = (verField != 2'b00);
    end
  end

  assign tokenChunks = chunkCnt;
  assign frameLen    = lenCnt;
endmodule

// File: rtl/rxv_control.sv
module rxv_control
  import rxv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxLast,
  input  logic       busGrant,
  input  logic       fifoEmpty,
  input  logic       fifoOne,
  input  logic       fifoFull,
  output rxvStrobe_t strb,
  output logic       busReq,
  output logic       tokenValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_DROP, ST_DONE} rxvState_e;

  rxvState_e state, stateNext;
  logic      lastSeen, dropped;
  logic      overflow;

  always_comb begin
    stateNext    = state;
    strb         = '0;
    strb.dropped = dropped;
    overflow     = 1'b0;
    case (state)
      ST_IDLE, ST_DONE: begin
        stateNext = ST_IDLE;
        if (rxValid) begin
          strb.start = 1'b1;
          strb.push  = 1'b1;
          stateNext  = ST_RECV;
        end
      end
      ST_RECV: begin
        strb.pop = busGrant && !fifoEmpty;
        if (rxValid && !lastSeen) begin
          if (!fifoFull || strb.pop) begin
            strb.push = 1'b1;
          end else begin
            overflow   = 1'b1;
            strb.flush = 1'b1;
            strb.pop   = 1'b0;
            stateNext  = rxLast ? ST_DONE : ST_DROP;
          end
        end
        // Finish in the cycle of the final write so the token follows it directly
        if (lastSeen && (fifoEmpty || (fifoOne && strb.pop))) stateNext = ST_DONE;
      end
      ST_DROP: begin
        if (rxValid && rxLast) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastSeen <= 1'b0;
      dropped  <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.start) begin
        lastSeen <= rxLast;
        dropped  <= 1'b0;
      end else begin
        if (strb.push && rxLast) lastSeen <= 1'b1;
        if (overflow)            dropped  <= 1'b1;
      end
    end
  end

  assign busReq     = (state == ST_RECV);
  assign tokenValid = (state == ST_DONE);
endmodule

// File: rtl/rx_frame_validator.sv
module rx_frame_validator
  import rxv_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int CHUNK_BYTES = 16,
  parameter int LEN_W       = 16,
  parameter int CHUNK_CNT_W = 12,
  parameter int MIN_LEN     = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   initLoad,
  input  logic [31:0]            initSeed,
  input  logic [31:0]            initResidue,
  input  logic [LEN_W-1:0]       maxLen,
  input  logic                   rxValid,
  input  logic [7:0]             rxData,
  input  logic                   rxLast,
  output logic                   busReq,
  input  logic                   busGrant,
  output logic                   memWrite,
  output logic [7:0]             memData,
  output logic                   allocStrobe,
  output logic                   tokenValid,
  output logic                   tokenAccept,
  output logic                   tokenRelease,
  output logic [STAT_W-1:0]      tokenStatus,
  output logic [CHUNK_CNT_W-1:0] tokenChunks,
  output logic [LEN_W-1:0]       frameLen
);
  rxvStrobe_t strb;
  logic       fifoEmpty, fifoOne, fifoFull;

  rxv_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .rxValid    (rxValid),
    .rxLast     (rxLast),
    .busGrant   (busGrant),
    .fifoEmpty  (fifoEmpty),
    .fifoOne    (fifoOne),
    .fifoFull   (fifoFull),
    .strb       (strb),
    .busReq     (busReq),
    .tokenValid (tokenValid)
  );

  rxv_datapath #(
    .DEPTH       (DEPTH),
    .CHUNK_BYTES (CHUNK_BYTES),
    .LEN_W       (LEN_W),
    .CHUNK_CNT_W (CHUNK_CNT_W),
    .MIN_LEN     (MIN_LEN)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .initLoad    (initLoad),
    .initSeed    (initSeed),
    .initResidue (initResidue),
    .maxLen      (maxLen),
    .rxData      (rxData),
    .strb        (strb),
    .fifoEmpty   (fifoEmpty),
    .fifoOne     (fifoOne),
    .fifoFull    (fifoFull),
    .memData     (memData),
    .allocStrobe (allocStrobe),
    .tokenStatus (tokenStatus),
    .tokenChunks (tokenChunks),
    .frameLen    (frameLen)
  );

  assign memWrite     = strb.pop;
  assign tokenAccept  = tokenValid && (tokenStatus == '0);
  assign tokenRelease = tokenValid && (tokenStatus != '0);
endmodule

// File: rtl/rx_frame_validator_chk.sv
module rx_frame_validator_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busReq,
  input logic       busGrant,
  input logic       memWrite,
  input logic       allocStrobe,
  input logic       tokenValid,
  input logic       tokenAccept,
  input logic       tokenRelease,
  input logic [3:0] tokenStatus
);
  // R1: quiet outputs while held in reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> (!busReq && !memWrite && !allocStrobe && !tokenValid));

  // R6: writes only under an active request and grant
  assert_write_needs_grant_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (busGrant && busReq));

  // R6: request is dropped in the token cycle
  assert_req_low_at_token_R6: assert property (@(posedge clk) disable iff (!rstN)
    tokenValid |-> !busReq);

  // R7: an overrun reports no other flag
  assert_overrun_alone_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tokenValid && tokenStatus[3]) |-> (tokenStatus[2:0] == 3'b000));

  // R8: chunk reservation only alongside a write
  assert_alloc_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    allocStrobe |-> memWrite);

  // R9: single-cycle token
  assert_token_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    tokenValid |=> !tokenValid);

  // R9: exactly one of accept and release with a token, neither without
  assert_token_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    tokenValid |-> $onehot({tokenAccept, tokenRelease}));

  assert_token_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tokenValid |-> !(tokenAccept || tokenRelease));
endmodule

bind rx_frame_validator rx_frame_validator_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busReq       (busReq),
  .busGrant     (busGrant),
  .memWrite     (memWrite),
  .allocStrobe  (allocStrobe),
  .tokenValid   (tokenValid),
  .tokenAccept  (tokenAccept),
  .tokenRelease (tokenRelease),
  .tokenStatus  (tokenStatus)
);

// File: tb/test_rx_frame_validator.sv
module test_rx_frame_validator;
  localparam int DEPTH   = 8;
  localparam int MAX_LEN = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initLoad = 1'b0;
  logic [31:0] initSeed = '0;
  logic [31:0] initResidue = '0;
  logic [15:0] maxLen = 16'(MAX_LEN);
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxLast = 1'b0;
  logic        busReq;
  logic        busGrant = 1'b0;
  logic        memWrite;
  logic [7:0]  memData;
  logic        allocStrobe;
  logic        tokenValid, tokenAccept, tokenRelease;
  logic [3:0]  tokenStatus;
  logic [11:0] tokenChunks;
  logic [15:0] frameLen;

  rx_frame_validator i_rx_frame_validator (
    .clk(clk), .rstN(rstN), .initLoad(initLoad), .initSeed(initSeed),
    .initResidue(initResidue), .maxLen(maxLen), .rxValid(rxValid),
    .rxData(rxData), .rxLast(rxLast), .busReq(busReq), .busGrant(busGrant),
    .memWrite(memWrite), .memData(memData), .allocStrobe(allocStrobe),
    .tokenValid(tokenValid), .tokenAccept(tokenAccept),
    .tokenRelease(tokenRelease), .tokenStatus(tokenStatus),
    .tokenChunks(tokenChunks), .frameLen(frameLen)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  logic [7:0]  fr  [64];
  logic [7:0]  cap [64];
  logic [31:0] benchSeed    = 32'hFFFFFFFF;
  logic [31:0] benchResidue = 32'hDEBB20E3;

  // Monitor state, sampled at the falling edge
  int cyc = 0, startCyc = -10, lastByteCyc = 0, lastWrCyc = 0, tokCyc = 0;
  int nWr = 0, nAlloc = 0, nTok = 0;
  bit reqAfter = 1'b0, badWrite = 1'b0;
  logic [3:0]  tStat;
  logic        tAcc, tRel;
  logic [11:0] tChunks;
  logic [15:0] tLen;

  always @(negedge clk) begin
    cyc++;
    if (rxValid && rxLast) lastByteCyc = cyc;
    if (memWrite) begin
      if (nWr < 64) cap[nWr] = memData;
      nWr++;
      lastWrCyc = cyc;
      if (!busGrant) badWrite = 1'b1;
    end
    if (allocStrobe) nAlloc++;
    if (cyc == startCyc + 1) reqAfter = busReq;
    if (tokenValid) begin
      nTok++;
      tokCyc  = cyc;
      tStat   = tokenStatus;
      tAcc    = tokenAccept;
      tRel    = tokenRelease;
      tChunks = tokenChunks;
      tLen    = frameLen;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crcModel(input logic [31:0] seed, input int n);
    logic [31:0] c = seed;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic mkFrame(input int len, input logic [1:0] ver, input bit badFcs,
                         input logic [31:0] seed);
    logic [31:0] fcs;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    fr[0][1:0] = ver;
    if (len >= 5) begin
      fcs = ~crcModel(seed, len - 4);
      for (int j = 0; j < 4; j++) fr[len-4+j] = fcs[8*j +: 8];
      if (badFcs) fr[len-1] ^= 8'h01;
    end
  endtask

  task automatic runFrame(input int len, input int gd, input string tag);
    bit ovr, crcOk, lenBad, dataOk;
    logic [3:0] expStat;
    int expChunks;
    nWr = 0; nAlloc = 0; nTok = 0; badWrite = 1'b0; reqAfter = 1'b0;
    fork
      begin
        for (int i = 0; i < len; i++) begin
          @(posedge clk); #1;
          if (i == 0) startCyc = cyc + 1;
          rxValid = 1'b1;
          rxData  = fr[i];
          rxLast  = (i == len - 1);
        end
        @(posedge clk); #1;
        rxValid = 1'b0;
        rxLast  = 1'b0;
      end
      begin
        repeat (gd + 1) @(posedge clk);
        #1 busGrant = 1'b1;
      end
    join
    for (int w = 0; w < 300 && nTok == 0; w++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1 busGrant = 1'b0;
    @(posedge clk);

    ovr       = (len > DEPTH) && (gd > DEPTH);
    crcOk     = (crcModel(benchSeed, len) == benchResidue);
    lenBad    = (len < 14) || (len > MAX_LEN);
    expStat   = ovr ? 4'b1000 : {1'b0, fr[0][1:0] != 2'b00, lenBad, !crcOk};
    expChunks = ovr ? 0 : (len + 15) / 16;

    // R9: one token, accept/release agree with status
    chk(nTok == 1, "R9", {tag, " token count"}, nTok, 1);
    // R2 R4 R5 R7: status flags
    chk(tStat == expStat, "R2/R4/R5/R7", {tag, " status"}, tStat, expStat);
    chk(tAcc == (expStat == 0) && tRel == (expStat != 0), "R9",
        {tag, " accept/release"}, {tAcc, tRel}, {expStat == 0, expStat != 0});
    if (ovr) begin
      // R7: dropped frame, token after last byte, no writes
      chk(tokCyc == lastByteCyc + 1, "R7", {tag, " token cycle"}, tokCyc, lastByteCyc + 1);
      chk(nWr == 0, "R7", {tag, " writes after overrun"}, nWr, 0);
    end else begin
      // R9: token one cycle after final write
      chk(tokCyc == lastWrCyc + 1, "R9", {tag, " token cycle"}, tokCyc, lastWrCyc + 1);
      dataOk = (nWr == len);
      for (int i = 0; i < len && i < 64; i++) if (cap[i] !== fr[i]) dataOk = 1'b0;
      // R6: bytes written in order
      chk(dataOk, "R6", {tag, " written bytes"}, nWr, len);
      // R4: length report
      chk(tLen == 16'(len), "R4", {tag, " frameLen"}, tLen, len);
    end
    // R8: chunk reservations
    chk(tChunks == 12'(expChunks) && nAlloc == expChunks, "R8", {tag, " chunks"},
        nAlloc, expChunks);
    // R6: request after first byte, never a write without grant
    chk(reqAfter == 1'b1, "R6", {tag, " busReq after first byte"}, reqAfter, 1);
    chk(!badWrite, "R6", {tag, " write without grant"}, badWrite, 0);
  endtask

  task automatic loadInit(input logic [31:0] s, input logic [31:0] r);
    @(posedge clk); #1;
    initLoad = 1'b1; initSeed = s; initResidue = r;
    @(posedge clk); #1;
    initLoad = 1'b0;
    benchSeed = s; benchResidue = r;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] rs;
    rs = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet in reset
    chk(!busReq && !memWrite && !allocStrobe, "R1", "req/write/alloc in reset",
        {busReq, memWrite, allocStrobe}, 0);
    chk(!tokenValid && !tokenAccept && !tokenRelease, "R1", "token in reset",
        {tokenValid, tokenAccept, tokenRelease}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(!busReq && !memWrite && !tokenValid, "R1", "idle after reset",
        {busReq, memWrite, tokenValid}, 0);

    // Directed corner cases
    mkFrame(20, 2'b00, 1'b0, benchSeed); runFrame(20, 0, "good20");          // R2
    mkFrame(20, 2'b00, 1'b1, benchSeed); runFrame(20, 2, "badcrc");          // R2
    mkFrame(10, 2'b00, 1'b0, benchSeed); runFrame(10, 1, "short10");         // R4
    mkFrame(14, 2'b00, 1'b0, benchSeed); runFrame(14, 1, "min14");           // R4
    mkFrame(50, 2'b00, 1'b0, benchSeed); runFrame(50, 3, "long50");          // R4
    mkFrame(40, 2'b00, 1'b0, benchSeed); runFrame(40, 0, "max40");           // R4
    mkFrame(20, 2'b01, 1'b0, benchSeed); runFrame(20, 0, "ver1");            // R5
    mkFrame(20, 2'b00, 1'b0, benchSeed); runFrame(20, DEPTH, "grantAtLimit"); // R6
    mkFrame(20, 2'b00, 1'b0, benchSeed); runFrame(20, DEPTH + 6, "overrun"); // R7
    mkFrame(DEPTH + 1, 2'b00, 1'b0, benchSeed); runFrame(DEPTH + 1, DEPTH + 3, "overrunOnLast"); // R7
    mkFrame(8, 2'b00, 1'b0, benchSeed); runFrame(8, 20, "stagedWait");       // R6
    mkFrame(32, 2'b00, 1'b0, benchSeed); runFrame(32, 0, "chunk32");         // R8
    mkFrame(33, 2'b00, 1'b0, benchSeed); runFrame(33, 1, "chunk33");         // R8

    // R3: frame built for a custom seed fails under defaults, passes once loaded
    mkFrame(24, 2'b00, 1'b0, 32'h1234_5678);
    runFrame(24, 0, "R3 before load");
    rs = crcModel(32'h1234_5678, 24);
    loadInit(32'h1234_5678, rs);
    runFrame(24, 0, "R3 after load");
    loadInit(32'hFFFFFFFF, 32'hDEBB20E3);

    // Constrained random frames
    for (int n = 0; n < 24; n++) begin
      int len, gd;
      logic [1:0] ver;
      bit bad;
      len = 10 + int'($urandom % 36);
      ver = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
      bad = ($urandom % 4 == 0);
      gd  = int'($urandom % (DEPTH + 5));
      mkFrame(len, ver, bad, benchSeed);
      runFrame(len, gd, "random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule